// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block sits between a bus master and a slow peripheral register whose single reads cannot be trusted. When a read request is accepted, the filter samples the addressed register again and again. Each sample is filed in a table that holds every distinct value seen so far and how often it occurred. The filter answers with the value that occurred most often.

Every sample is requested with a single-cycle strobe. Its answer comes back with a valid strobe, and the next sample is requested only after that answer has been filed. Filing walks the table from the oldest entry, one entry per cycle, and either raises the count of a matching entry or appends a new entry with a count of one. A running leader is replaced only when another entry's count goes strictly above the leader's count. Voting ends when the leader holds more than half of the sample limit, or when the limit itself is reached. The result is then presented for one cycle.

Top module: `majority_read_filter`

## Requirements
- R1: No accepted request causes more than MAX_SAMPLES (100) sample strobes. When no value's count ever goes above MAX_SAMPLES/2, exactly MAX_SAMPLES strobes are issued.
- R2: Voting ends right after the sample that lifts one value's count above MAX_SAMPLES/2, which is 51 with the default limit. No strobe follows that sample.
- R3: The `rsp_data` presented with `rsp_done` is the value that occurred most often among the samples taken for that request.
- R4: When several values share the highest count, the result is the value that reached that count first. When every sample differs, the result is the first sample.
- R5: `smp_req` is high for one cycle at a time, and at most one sample is outstanding. A new strobe follows only after the previous sample has returned on `smp_valid` and been filed.
- R6: A `req_valid` that arrives while a vote is running is ignored. It produces no second `rsp_done`, no extra strobes and no change of `smp_addr`.
- R7: `rsp_done` is a one-cycle pulse, given exactly once for each accepted request. `smp_addr` carries the accepted request's address for every sample of that vote.
- R8: Each request starts from an empty table and a cleared leader. Values and counts from earlier requests have no effect on the result.
- R9: While reset is asserted, and after it is released (including a reset in the middle of a vote), `smp_req` and `rsp_done` stay low until a new request is accepted.
- R10: Filing walks the table one entry per cycle. The next strobe comes k+3 cycles after the cycle in which `smp_valid` was high. Here k is the position of the matching entry (0 for the first value seen), or the number of entries already in the table when the value is new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request strobe, accepted only when idle |
| req_addr | input | ADDR_W | Register address of the request |
| smp_req | output | 1 | One-cycle strobe asking the peripheral for a sample |
| smp_addr | output | ADDR_W | Address being sampled, held for the whole vote |
| smp_valid | input | 1 | Peripheral answer strobe for the outstanding sample |
| smp_data | input | DATA_W | Sampled register value, qualified by smp_valid |
| rsp_done | output | 1 | One-cycle pulse marking the result |
| rsp_data | output | DATA_W | Winning value, valid with rsp_done |

## Verification
The bench builds the filter with its default parameters: 32-bit data, 8-bit addresses and a 100-sample limit. At this size the 51-sample early stop, a 50/50 tie running to the full limit and a completely filled 100-entry table of distinct values can all be reached. With the limit this large, the leader can also change late in a vote. The peripheral model answers one cycle after each strobe, so the gap between an answer and the next strobe measures the table position directly.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SEARCH,
    ST_DECIDE
  } vote_state_e;

  // A candidate displaces the leader only with a strictly higher count.
  function automatic bit outranks(int unsigned cand, int unsigned lead);
    return cand > lead;
  endfunction

  // A count above half of the sample limit ends the vote early.
  function automatic bit clears_half(int unsigned cnt, int unsigned limit);
    return cnt > (limit / 2);
  endfunction

  // Count stored for a filed sample: fresh entries start at one.
  function automatic int unsigned bumped(bit fresh, int unsigned old_cnt);
    return fresh ? 1 : old_cnt + 1;
  endfunction

endpackage

// File: rtl/mvf_table.sv
module mvf_table #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 100,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [PTR_W-1:0]  wr_cnt,
  output logic [DATA_W-1:0] rd_val,
  output logic [PTR_W-1:0]  rd_cnt,
  output logic [PTR_W-1:0]  fill
);

  logic [DATA_W-1:0] val_w [DEPTH];
  logic [PTR_W-1:0]  cnt_w [DEPTH];
  logic [PTR_W-1:0]  fill_q;
  logic              tail_write;

  // Entries are only meaningful below the fill pointer, so they carry no reset.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic [DATA_W-1:0] v_q;
      logic [PTR_W-1:0]  c_q;
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == PTR_W'(i))) begin
          v_q <= wr_val;
          c_q <= wr_cnt;
        end
      end
      assign val_w[i] = v_q;
      assign cnt_w[i] = c_q;
    end
  endgenerate

  assign tail_write = wr_en && (wr_idx == fill_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_q <= '0;
    else if (clear)      fill_q <= '0;
    else if (tail_write) fill_q <= fill_q + PTR_W'(1);
  end

  always_comb begin
    rd_val = '0;
    rd_cnt = '0;
    if (32'(rd_idx) < DEPTH) begin
      rd_val = val_w[rd_idx];
      rd_cnt = cnt_w[rd_idx];
    end
  end

  assign fill = fill_q;

  // R8: writes either update a filed entry or extend the tail, never skip past it
  p_write_in_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= fill_q));

  // R1: the table never holds more entries than samples allowed
  p_fill_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_q) <= DEPTH);

endmodule

// File: rtl/mvf_tally.sv
module mvf_tally #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 7,
  parameter int LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              file_en,
  input  logic [DATA_W-1:0] file_val,
  input  logic [PTR_W-1:0]  file_cnt,
  output logic [DATA_W-1:0] lead_val,
  output logic              majority
);
  import mvf_pkg::*;

  logic [PTR_W-1:0] lead_cnt_q;
  logic [DATA_W-1:0] lead_val_q;
  logic             take_lead;

  assign take_lead = file_en && outranks(32'(file_cnt), 32'(lead_cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt_q <= '0;
      lead_val_q <= '0;
    end else if (clear) begin
      lead_cnt_q <= '0;
      lead_val_q <= '0;
    end else if (take_lead) begin
      lead_cnt_q <= file_cnt;
      lead_val_q <= file_val;
    end
  end

  assign lead_val = lead_val_q;
  assign majority = clears_half(32'(lead_cnt_q), LIMIT);

  // R4: the leading count never drops while samples are filed
  p_lead_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (file_en && !clear) |=> (lead_cnt_q >= $past(lead_cnt_q)));

  // R4: equalling the leader's count keeps the earlier leader
  p_tie_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (file_en && !clear && (file_cnt == lead_cnt_q)) |=> $stable(lead_val_q));

endmodule

// File: rtl/mvf_sequencer.sv
module mvf_sequencer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 7,
  parameter int LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              smp_req,
  output logic [ADDR_W-1:0] smp_addr,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              rsp_done,
  output logic              start_evt,
  output logic [PTR_W-1:0]  walk_idx,
  output logic              file_evt,
  output logic [DATA_W-1:0] file_val,
  output logic [PTR_W-1:0]  file_cnt,
  input  logic [DATA_W-1:0] rd_val,
  input  logic [PTR_W-1:0]  rd_cnt,
  input  logic [PTR_W-1:0]  fill,
  input  logic              majority
);
  import mvf_pkg::*;

  vote_state_e       state_q;
  logic [PTR_W-1:0]  walk_q;
  logic [PTR_W-1:0]  taken_q;
  logic [DATA_W-1:0] sample_q;
  logic [ADDR_W-1:0] addr_q;
  logic              owed_q;

  logic at_tail, hit, stop, limit_hit;

  assign start_evt = (state_q == ST_IDLE) && req_valid;
  assign at_tail   = (walk_q == fill);
  assign hit       = !at_tail && (rd_val == sample_q);
  assign file_evt  = (state_q == ST_SEARCH) && (hit || at_tail);
  assign limit_hit = (taken_q == PTR_W'(LIMIT));
  assign stop      = majority || limit_hit;
  assign rsp_done  = (state_q == ST_DECIDE) && stop;
  assign smp_req   = (state_q == ST_ISSUE);
  assign smp_addr  = addr_q;
  assign walk_idx  = walk_q;
  assign file_val  = sample_q;
  assign file_cnt  = PTR_W'(bumped(at_tail, 32'(rd_cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      walk_q   <= '0;
      taken_q  <= '0;
      sample_q <= '0;
      addr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_evt) begin
          addr_q  <= req_addr;
          taken_q <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (smp_valid) begin
          sample_q <= smp_data;
          walk_q   <= '0;
          state_q  <= ST_SEARCH;
        end
        ST_SEARCH: if (file_evt) begin
          taken_q <= taken_q + PTR_W'(1);
          state_q <= ST_DECIDE;
        end else begin
          walk_q <= walk_q + PTR_W'(1);
        end
        ST_DECIDE: state_q <= stop ? ST_IDLE : ST_ISSUE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker state: one sample in flight between a strobe and its filing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owed_q <= 1'b0;
    else if (smp_req)  owed_q <= 1'b1;
    else if (file_evt) owed_q <= 1'b0;
  end

  // R5: each strobe lasts a single cycle
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |=> !smp_req);

  // R5: no new strobe while an earlier sample is still unfiled
  p_one_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> !owed_q);

  // R1: a strobe is never issued once the limit has been taken
  p_sample_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> (taken_q < PTR_W'(LIMIT)));

  // R2: no sampling continues after a strict majority exists
  p_stop_on_majority_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> !majority);

  // R7: the result strobe is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R6: the sampled address only moves when a request is accepted
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(smp_addr));

endmodule

// File: rtl/majority_read_filter.sv
module majority_read_filter #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int MAX_SAMPLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              smp_req,
  output logic [ADDR_W-1:0] smp_addr,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int PTR_W = $clog2(MAX_SAMPLES + 1);

  logic              start_evt;
  logic [PTR_W-1:0]  walk_idx;
  logic              file_evt;
  logic [DATA_W-1:0] file_val;
  logic [PTR_W-1:0]  file_cnt;
  logic [DATA_W-1:0] rd_val;
  logic [PTR_W-1:0]  rd_cnt;
  logic [PTR_W-1:0]  fill;
  logic              majority;

  mvf_sequencer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LIMIT(MAX_SAMPLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .smp_req(smp_req), .smp_addr(smp_addr),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .rsp_done(rsp_done),
    .start_evt(start_evt), .walk_idx(walk_idx),
    .file_evt(file_evt), .file_val(file_val), .file_cnt(file_cnt),
    .rd_val(rd_val), .rd_cnt(rd_cnt), .fill(fill),
    .majority(majority)
  );

  mvf_table #(
    .DATA_W(DATA_W), .DEPTH(MAX_SAMPLES), .PTR_W(PTR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .clear(start_evt),
    .rd_idx(walk_idx),
    .wr_en(file_evt), .wr_idx(walk_idx), .wr_val(file_val), .wr_cnt(file_cnt),
    .rd_val(rd_val), .rd_cnt(rd_cnt), .fill(fill)
  );

  mvf_tally #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .LIMIT(MAX_SAMPLES)
  ) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(start_evt),
    .file_en(file_evt), .file_val(file_val), .file_cnt(file_cnt),
    .lead_val(rsp_data), .majority(majority)
  );

endmodule

// File: tb/test_majority_read_filter.sv
module test_majority_read_filter;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_addr;
  logic        smp_req;
  logic [7:0]  smp_addr;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        rsp_done;
  logic [31:0] rsp_data;

  majority_read_filter i_majority_read_filter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .smp_req(smp_req), .smp_addr(smp_addr),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Peripheral model state
  logic [2:0]  cur_kind = 3'd0;
  logic [31:0] cur_a = '0, cur_b = '0;
  logic [7:0]  exp_addr = '0;
  int j = 0, strobes = 0, dones = 0, addr_err = 0, cyc = 0, last_valid = 0;
  bit pend = 1'b0;
  int gaps [128];

  // Sample sequences, index i counts from zero
  function automatic logic [31:0] pat(logic [2:0] k, logic [31:0] a, logic [31:0] b, int i);
    case (k)
      3'd0: return a;
      3'd1: return (i % 2 == 1) ? b : a;
      3'd2: return (i < 10) ? b : a;
      3'd3: return (i % 3 == 0) ? a : ((i % 3 == 1) ? b : (a ^ b));
      3'd4: return (i < 49) ? b : a;
      3'd5: return a + 32'(i);
      3'd6: return (i % 4 == 0) ? b : a;
      default: return a;
    endcase
  endfunction

  // Answers each strobe one cycle later; all activity on the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      pend = 1'b0;
      smp_valid = 1'b0;
    end else begin
      smp_valid = pend;
      if (pend) begin
        smp_data = pat(cur_kind, cur_a, cur_b, j);
        last_valid = cyc;
        j = j + 1;
      end
      if (smp_req) begin
        strobes = strobes + 1;
        if (j > 0 && j <= 128) gaps[j-1] = cyc - last_valid;
        if (smp_addr != exp_addr) addr_err = addr_err + 1;
      end
      if (rsp_done) dones = dones + 1;
      pend = smp_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_vote(input logic [7:0] addr, input logic [2:0] k,
                            input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cur_kind = k; cur_a = a; cur_b = b;
    j = 0; strobes = 0; dones = 0; addr_err = 0; exp_addr = addr;
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int inject_at, output logic [31:0] res, output bit got);
    int n = 0;
    got = 1'b0;
    res = '0;
    while (!got && n < 20000) begin
      @(negedge clk);
      n++;
      if (rsp_done) begin got = 1'b1; res = rsp_data; end
      if (inject_at > 0 && n == inject_at) begin
        req_valid = 1'b1; req_addr = exp_addr ^ 8'hFF;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    if (!got) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=no_done expected=done");
    end
    repeat (5) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] want;
    logic [7:0]  n_want;
  } vec_t;

  // R2 early stop, R8 stale entry reuse, R4 tie, R3 plurality, R1 full table
  localparam vec_t VECS [8] = '{
    '{3'd0, 32'hCAFE0001, 32'h00000000, 32'hCAFE0001, 8'd51},
    '{3'd2, 32'h12345678, 32'hCAFE0001, 32'h12345678, 8'd61},
    '{3'd1, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'hA5A5A5A5, 8'd100},
    '{3'd3, 32'h00000001, 32'h00000002, 32'h00000001, 8'd100},
    '{3'd4, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF, 8'd100},
    '{3'd5, 32'h00001000, 32'h00000000, 32'h00001000, 8'd100},
    '{3'd6, 32'h77770000, 32'h00007777, 32'h77770000, 8'd68},
    '{3'd0, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 8'd51}
  };

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] res;
    bit got;
    int s0, d0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; smp_valid = 1'b0; smp_data = '0;
    repeat (4) @(negedge clk);
    chk(!smp_req && !rsp_done, "R9 reset idle", {30'd0, smp_req, rsp_done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!smp_req && !rsp_done, "R9 idle after reset", {30'd0, smp_req, rsp_done}, 32'd0);

    for (int v = 0; v < 8; v++) begin
      start_vote(8'h40 + 8'(v), VECS[v].kind, VECS[v].a, VECS[v].b);
      wait_done(0, res, got);
      chk(res == VECS[v].want, $sformatf("R3 R4 vec%0d result", v), res, VECS[v].want);
      chk(strobes == int'(VECS[v].n_want), $sformatf("R1 R2 vec%0d strobes", v),
          32'(strobes), 32'(VECS[v].n_want));
      chk(dones == 1 && addr_err == 0, $sformatf("R7 vec%0d done once, addr held", v),
          32'(dones * 256 + addr_err), 32'd256);
    end

    // R10: walk length shows in the gap between an answer and the next strobe
    start_vote(8'h5C, 3'd3, 32'h1, 32'h2);
    wait_done(0, res, got);
    chk(gaps[2] == 5, "R10 new entry at position 2", 32'(gaps[2]), 32'd5);
    chk(gaps[3] == 3, "R10 match at position 0", 32'(gaps[3]), 32'd3);
    chk(gaps[4] == 4, "R10 match at position 1", 32'(gaps[4]), 32'd4);
    chk(gaps[0] == 3, "R5 R10 first sample filed before next strobe", 32'(gaps[0]), 32'd3);

    // R6: request during a vote is ignored
    start_vote(8'h11, 3'd0, 32'hBEEF0042, 32'h0);
    wait_done(20, res, got);
    repeat (300) @(negedge clk);
    chk(res == 32'hBEEF0042, "R6 result unaffected", res, 32'hBEEF0042);
    chk(dones == 1, "R6 single done", 32'(dones), 32'd1);
    chk(strobes == 51 && addr_err == 0, "R6 no extra strobes, address held",
        32'(strobes * 256 + addr_err), 32'(51 * 256));

    // R9: reset in the middle of a vote
    start_vote(8'h22, 3'd0, 32'h0BAD0BAD, 32'h0);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!smp_req && !rsp_done, "R9 outputs low in reset", {30'd0, smp_req, rsp_done}, 32'd0);
    rst_n = 1'b1;
    s0 = strobes; d0 = dones;
    repeat (200) @(negedge clk);
    chk(strobes == s0 && dones == d0, "R9 no activity after reset",
        32'(strobes - s0 + dones - d0), 32'd0);
    start_vote(8'h23, 3'd2, 32'h600DF00D, 32'h0BAD0BAD);
    wait_done(0, res, got);
    chk(res == 32'h600DF00D && strobes == 61, "R9 R8 clean vote after reset",
        res, 32'h600DF00D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule